// File: doc/BRIEF.md
# PWM Channel Configuration Register File

This block is the bus-facing register file of a multi-channel pulse-width modulator. It sits on an APB bus, stores one shared clock setting plus a bank of control, period, duty and deadband values for each channel, and drives those values out to the channel counters, which live elsewhere. A channel-select register picks which bank the per-channel offsets reach, so one small address window serves any number of channels.

Each channel reports three edge and half-period flags. These flags are merged into the read image of its control register as read-only bits. Software asks a channel to take new period and duty values by setting a load bit. That bit stays set until the channel signals that it has taken the values, and then it clears itself. Misaligned accesses, unmapped offsets, byte-wide writes and banked accesses to a channel that does not exist all get a slave error and change nothing.

Top module: `pwm_apb_regs`

## Requirements
- R1: After a synchronous reset every register and output is 0: the clock setting, the channel select, every bank, every load request, `prdata` and `pslverr`.
- R2: The word at offset 0x00 holds the shared clock setting. Bit 0 drives `clk_src_o` (1 external, 0 internal) and bits 15:1 drive `prescale_o`. Both read back unchanged.
- R3: The word at offset 0x14 holds the channel select in its low `SEL_W` bits, and it reads back. Offsets 0x04, 0x08, 0x0C and 0x10 reach only the selected channel's bank. When the select is at or above `NUM_CH`, those four offsets give a slave error, while 0x00 and 0x14 still work.
- R4: In the control word at 0x04, bits 8:0 are read-write and drive that channel's slice of `ch_ctrl_o`. Bits 11:9 read the channel's `status_i` slice (bit 9 half period, bit 10 fall, bit 11 rise) and ignore writes. Bits 15:13 read 0.
- R5: Writing 1 to control bit 12 raises that channel's `load_req_o`, and the bit reads back as 1. Writing 0 to it does not clear it. It clears on the clock edge that samples the channel's `load_done_i` high.
- R6: Offsets 0x08, 0x0C and 0x10 hold the selected channel's period, duty and deadband. Each is 16 bits, reads back, and drives its own slice of `ch_period_o`, `ch_duty_o` and `ch_dead_o`.
- R7: A write with `pstrb` 4'b0011 or 4'b1111 updates bits 15:0. A write with `pstrb` 4'b1100 is accepted without error and leaves the register unchanged. Read data bits 31:16 are always 0.
- R8: An address with `paddr[1:0]` not 0, an offset outside the defined set, or a write whose `pstrb` is not 0011, 1100 or 1111 gives `pslverr`=1 with `prdata`=0 in the access phase, and the access changes no register.
- R9: `pready` is always 1. `pslverr` and `prdata` are 0 in every cycle that is not an access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | Byte address inside the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte strobes |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Slave error, valid in the access phase |
| clk_src_o | output | 1 | Shared clock source select |
| prescale_o | output | 15 | Shared clock divisor |
| ch_ctrl_o | output | NUM_CH*9 | Control bits 8:0, one slice per channel |
| ch_period_o | output | NUM_CH*16 | Period per channel |
| ch_duty_o | output | NUM_CH*16 | Duty per channel |
| ch_dead_o | output | NUM_CH*16 | Deadband per channel |
| load_req_o | output | NUM_CH | Pending load request per channel |
| load_done_i | input | NUM_CH | Channel has taken its shadow values |
| status_i | input | NUM_CH*3 | Per-channel flags {rise, fall, half} |

## Verification
Assertions check several rules on every cycle: the load request holds until done and then drops, an erroring access leaves every configuration output stable, a misaligned address always errors, and the response outputs stay quiet outside access phases. Only the bench scenarios can show that the right channel's bank is reached through the select register. They also show the merged read image with the status bits, that a 4'b1100 strobe is a silent no-op, and that an out-of-range select blocks the banked offsets but not the global ones.

// File: rtl/pwm_regs_pkg.sv
package pwm_regs_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned CTRL_RW_W = 9;
  localparam int unsigned STAT_W    = 3;
  localparam int unsigned LOAD_BIT  = 12;

  localparam int unsigned OFS_CLK    = 'h00;
  localparam int unsigned OFS_CTRL   = 'h04;
  localparam int unsigned OFS_PERIOD = 'h08;
  localparam int unsigned OFS_DUTY   = 'h0C;
  localparam int unsigned OFS_DEAD   = 'h10;
  localparam int unsigned OFS_CSEL   = 'h14;

  typedef enum logic [2:0] {
    RG_NONE, RG_CLK, RG_CTRL, RG_PERIOD, RG_DUTY, RG_DEAD, RG_CSEL
  } reg_sel_e;

  function automatic logic [REG_W-1:0] lane_merge(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] new_v,
    input logic [1:0]       be
  );
    lane_merge = {be[1] ? new_v[15:8] : old_v[15:8],
                  be[0] ? new_v[7:0]  : old_v[7:0]};
  endfunction
endpackage

// File: rtl/pwm_apb_decode.sv
module pwm_apb_decode
  import pwm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic [3:0]        pstrb,
  input  logic [SEL_W-1:0]  ch_sel,
  output reg_sel_e          sel,
  output logic              err
);
  logic banked, bad_ch, bad_strb;

  always_comb begin
    case (paddr)
      ADDR_W'(OFS_CLK):    sel = RG_CLK;
      ADDR_W'(OFS_CTRL):   sel = RG_CTRL;
      ADDR_W'(OFS_PERIOD): sel = RG_PERIOD;
      ADDR_W'(OFS_DUTY):   sel = RG_DUTY;
      ADDR_W'(OFS_DEAD):   sel = RG_DEAD;
      ADDR_W'(OFS_CSEL):   sel = RG_CSEL;
      default:             sel = RG_NONE;
    endcase
  end

  assign banked   = (sel == RG_CTRL) || (sel == RG_PERIOD) ||
                    (sel == RG_DUTY) || (sel == RG_DEAD);
  assign bad_ch   = banked && (int'(ch_sel) >= int'(NUM_CH));
  assign bad_strb = pwrite && !((pstrb == 4'b0011) || (pstrb == 4'b1100) ||
                                (pstrb == 4'b1111));
  assign err      = (sel == RG_NONE) || bad_ch || bad_strb;
endmodule

// File: rtl/pwm_chan_bank.sv
module pwm_chan_bank
  import pwm_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_ctrl,
  input  logic                 wr_period,
  input  logic                 wr_duty,
  input  logic                 wr_dead,
  input  logic [REG_W-1:0]     wdata,
  input  logic [1:0]           wbe,
  input  logic                 load_done,
  output logic [CTRL_RW_W-1:0] ctrl_o,
  output logic [REG_W-1:0]     period_o,
  output logic [REG_W-1:0]     duty_o,
  output logic [REG_W-1:0]     dead_o,
  output logic                 load_req_o
);
  logic [REG_W-1:0] ctrl_merged;
  logic             load_set;

  assign ctrl_merged = lane_merge({{(REG_W-CTRL_RW_W){1'b0}}, ctrl_o}, wdata, wbe);
  assign load_set    = wr_ctrl && wbe[1] && wdata[LOAD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o     <= '0;
      period_o   <= '0;
      duty_o     <= '0;
      dead_o     <= '0;
      load_req_o <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_o   <= ctrl_merged[CTRL_RW_W-1:0];
      if (wr_period) period_o <= lane_merge(period_o, wdata, wbe);
      if (wr_duty)   duty_o   <= lane_merge(duty_o, wdata, wbe);
      if (wr_dead)   dead_o   <= lane_merge(dead_o, wdata, wbe);
      if (load_set)       load_req_o <= 1'b1;
      else if (load_done) load_req_o <= 1'b0;
    end
  end

  // R5: a pending load survives until the channel reports done
  a_r5_load_holds: assert property (@(posedge clk) disable iff (rst)
    load_req_o && !load_done |=> load_req_o);
  // R5: done without a new request drops the load bit
  a_r5_load_clears: assert property (@(posedge clk) disable iff (rst)
    load_done && !load_set |=> !load_req_o);
  // R5: a write of 1 to the load bit raises the request
  a_r5_load_sets: assert property (@(posedge clk) disable iff (rst)
    load_set |=> load_req_o);
endmodule

// File: rtl/pwm_apb_regs.sv
module pwm_apb_regs
  import pwm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [31:0]              pwdata,
  input  logic [3:0]               pstrb,
  output logic [31:0]              prdata,
  output logic                     pready,
  output logic                     pslverr,
  output logic                     clk_src_o,
  output logic [14:0]              prescale_o,
  output logic [NUM_CH*9-1:0]      ch_ctrl_o,
  output logic [NUM_CH*16-1:0]     ch_period_o,
  output logic [NUM_CH*16-1:0]     ch_duty_o,
  output logic [NUM_CH*16-1:0]     ch_dead_o,
  output logic [NUM_CH-1:0]        load_req_o,
  input  logic [NUM_CH-1:0]        load_done_i,
  input  logic [NUM_CH*3-1:0]      status_i
);
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_sel_e             sel;
  logic                 dec_err;
  logic                 wr_go;
  logic [REG_W-1:0]     clk_q;
  logic [SEL_W-1:0]     csel_q;
  logic [REG_W-1:0]     rd_word;
  logic [1:0]           wbe;

  logic [CTRL_RW_W-1:0] ctrl_a   [NUM_CH];
  logic [REG_W-1:0]     period_a [NUM_CH];
  logic [REG_W-1:0]     duty_a   [NUM_CH];
  logic [REG_W-1:0]     dead_a   [NUM_CH];

  pwm_apb_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
    .paddr  (paddr),
    .pwrite (pwrite),
    .pstrb  (pstrb),
    .ch_sel (csel_q),
    .sel    (sel),
    .err    (dec_err)
  );

  assign wr_go = psel && penable && pwrite && !dec_err;
  assign wbe   = pstrb[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= '0;
      csel_q <= '0;
    end else if (wr_go) begin
      if (sel == RG_CLK)               clk_q  <= lane_merge(clk_q, pwdata[REG_W-1:0], wbe);
      if (sel == RG_CSEL && pstrb[0])  csel_q <= pwdata[SEL_W-1:0];
    end
  end

  assign clk_src_o  = clk_q[0];
  assign prescale_o = clk_q[15:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_go && (csel_q == SEL_W'(c));
    pwm_chan_bank u_bank (
      .clk        (clk),
      .rst        (rst),
      .wr_ctrl    (hit && sel == RG_CTRL),
      .wr_period  (hit && sel == RG_PERIOD),
      .wr_duty    (hit && sel == RG_DUTY),
      .wr_dead    (hit && sel == RG_DEAD),
      .wdata      (pwdata[REG_W-1:0]),
      .wbe        (wbe),
      .load_done  (load_done_i[c]),
      .ctrl_o     (ctrl_a[c]),
      .period_o   (period_a[c]),
      .duty_o     (duty_a[c]),
      .dead_o     (dead_a[c]),
      .load_req_o (load_req_o[c])
    );
    assign ch_ctrl_o[c*9 +: 9]     = ctrl_a[c];
    assign ch_period_o[c*16 +: 16] = period_a[c];
    assign ch_duty_o[c*16 +: 16]   = duty_a[c];
    assign ch_dead_o[c*16 +: 16]   = dead_a[c];
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      RG_CLK:  rd_word = clk_q;
      RG_CSEL: rd_word = REG_W'(csel_q);
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (csel_q == SEL_W'(c)) begin
            case (sel)
              RG_CTRL:   rd_word = {3'b000, load_req_o[c], status_i[c*3 +: 3], ctrl_a[c]};
              RG_PERIOD: rd_word = period_a[c];
              RG_DUTY:   rd_word = duty_a[c];
              RG_DEAD:   rd_word = dead_a[c];
              default:   rd_word = '0;
            endcase
          end
        end
      end
    endcase
  end

  // Response is captured at the setup edge so it is registered for the access phase
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata  <= '0;
      pslverr <= 1'b0;
    end else if (psel && !penable) begin
      prdata  <= dec_err ? 32'h0 : {16'h0, rd_word};
      pslverr <= dec_err;
    end else begin
      prdata  <= '0;
      pslverr <= 1'b0;
    end
  end

  assign pready = 1'b1;

  // R1: reset clears response and configuration
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (prdata == 32'h0 && !pslverr && load_req_o == '0 && clk_q == '0));
  // R9: response is quiet outside access phases
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable) |-> (!pslverr && prdata == 32'h0));
  // R8: misaligned address errors
  a_r8_misaligned_err: assert property (@(posedge clk) disable iff (rst)
    psel && !penable && (paddr[1:0] != 2'b00) |=> pslverr);
  // R8: an erroring write changes no configuration
  a_r8_err_no_effect: assert property (@(posedge clk) disable iff (rst)
    psel && penable && pwrite && pslverr |=>
      ($stable(ch_period_o) && $stable(ch_duty_o) && $stable(ch_dead_o) &&
       $stable(ch_ctrl_o) && $stable(clk_q)));
endmodule

// File: tb/pwm_apb_regs_test.sv
`timescale 1ns/1ps
module pwm_apb_regs_test;
  localparam int NUM_CH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0] pstrb = '0;
  logic [31:0] prdata;
  logic pready, pslverr, clk_src_o;
  logic [14:0] prescale_o;
  logic [NUM_CH*9-1:0] ch_ctrl_o;
  logic [NUM_CH*16-1:0] ch_period_o, ch_duty_o, ch_dead_o;
  logic [NUM_CH-1:0] load_req_o;
  logic [NUM_CH-1:0] load_done_i = '0;
  logic [NUM_CH*3-1:0] status_i = '0;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [31:0] d;
    logic        e;
    logic        is_rd;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  pwm_apb_regs #(.ADDR_W(8), .NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .clk_src_o(clk_src_o),
    .prescale_o(prescale_o), .ch_ctrl_o(ch_ctrl_o), .ch_period_o(ch_period_o),
    .ch_duty_o(ch_duty_o), .ch_dead_o(ch_dead_o), .load_req_o(load_req_o),
    .load_done_i(load_done_i), .status_i(status_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s, input logic [31:0] exp_d,
                     input logic exp_e, input string tag);
    exp_t it;
    it.d = exp_d; it.e = exp_e; it.is_rd = !wr; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a;
    pwdata = d; pstrb = wr ? s : 4'b0000;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d, input string tag);
    apb(1'b1, a, d, 4'b1111, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp_d,
                    input logic exp_e, input string tag);
    apb(1'b0, a, 32'h0, 4'b0000, exp_d, exp_e, tag);
  endtask

  // Monitor: compares each access phase with the next queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #3.5;
      if (psel && penable) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL monitor: unexpected access, actual err %b expected none", pslverr);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          chk({it.tag, " pslverr"}, {31'h0, pslverr}, {31'h0, it.e});
          chk({it.tag, " pready"}, {31'h0, pready}, 32'h1);
          if (it.is_rd) chk({it.tag, " prdata"}, prdata, it.d);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 prdata", prdata, 32'h0);
    chk("R1 pslverr", {31'h0, pslverr}, 32'h0);
    chk("R1 load_req", {26'h0, load_req_o}, 32'h0);
    chk("R1 period", ch_period_o[31:0], 32'h0);
    chk("R1 prescale", {17'h0, prescale_o}, 32'h0);
    rd(8'h00, 32'h0, 1'b0, "R1 clock read");

    // R2 clock register
    wr32(8'h00, 32'hFFFF_ABCD, "R2 clock write");
    chk("R2 clk_src", {31'h0, clk_src_o}, 32'h1);
    chk("R2 prescale", {17'h0, prescale_o}, 32'h0000_55E6);
    rd(8'h00, 32'h0000_ABCD, 1'b0, "R2 R7 clock read");

    // R3 R6 banked registers on channel 2
    wr32(8'h14, 32'h2, "R3 select 2");
    wr32(8'h08, 32'h1234, "R6 period");
    wr32(8'h0C, 32'h0800, "R6 duty");
    wr32(8'h10, 32'h0010, "R6 dead");
    chk("R6 period ch2", {16'h0, ch_period_o[2*16 +: 16]}, 32'h1234);
    chk("R6 duty ch2", {16'h0, ch_duty_o[2*16 +: 16]}, 32'h0800);
    chk("R6 dead ch2", {16'h0, ch_dead_o[2*16 +: 16]}, 32'h0010);
    rd(8'h08, 32'h1234, 1'b0, "R6 period read");
    rd(8'h14, 32'h2, 1'b0, "R3 select read");
    wr32(8'h14, 32'h0, "R3 select 0");
    wr32(8'h08, 32'h9999, "R3 period ch0");
    chk("R3 ch0 period", {16'h0, ch_period_o[0 +: 16]}, 32'h9999);
    chk("R3 ch2 untouched", {16'h0, ch_period_o[2*16 +: 16]}, 32'h1234);
    rd(8'h08, 32'h9999, 1'b0, "R3 period ch0 read");

    // R4 R5 control with merged status
    status_i = '0;
    status_i[2*3 +: 3] = 3'b101;
    status_i[0 +: 3]   = 3'b010;
    wr32(8'h14, 32'h2, "R3 select 2 again");
    apb(1'b1, 8'h04, 32'h0000_FFFF, 4'b0011, 32'h0, 1'b0, "R4 ctrl write");
    chk("R4 ctrl bits", {23'h0, ch_ctrl_o[2*9 +: 9]}, 32'h1FF);
    chk("R5 load raised", {31'h0, load_req_o[2]}, 32'h1);
    chk("R4 other ch ctrl", {23'h0, ch_ctrl_o[0 +: 9]}, 32'h0);
    rd(8'h04, 32'h0000_1BFF, 1'b0, "R4 R5 ctrl read");
    wr32(8'h04, 32'h0, "R5 write zero");
    chk("R5 load held", {31'h0, load_req_o[2]}, 32'h1);
    rd(8'h04, 32'h0000_1A00, 1'b0, "R5 ctrl read held");
    @(negedge clk);
    load_done_i = 6'b000100;
    @(negedge clk);
    load_done_i = '0;
    chk("R5 load cleared", {31'h0, load_req_o[2]}, 32'h0);
    rd(8'h04, 32'h0000_0A00, 1'b0, "R5 ctrl read cleared");

    // R7 upper-lane strobe is a no-op
    apb(1'b1, 8'h08, 32'h5555_5555, 4'b1100, 32'h0, 1'b0, "R7 upper strobe");
    chk("R7 period kept", {16'h0, ch_period_o[2*16 +: 16]}, 32'h1234);
    apb(1'b1, 8'h0C, 32'hAAAA_4321, 4'b0011, 32'h0, 1'b0, "R7 low strobe");
    rd(8'h0C, 32'h0000_4321, 1'b0, "R7 low strobe read");

    // R8 errors
    rd(8'h18, 32'h0, 1'b1, "R8 unmapped");
    rd(8'h06, 32'h0, 1'b1, "R8 misaligned");
    apb(1'b1, 8'h08, 32'h7777, 4'b0001, 32'h0, 1'b1, "R8 byte write");
    chk("R8 period kept", {16'h0, ch_period_o[2*16 +: 16]}, 32'h1234);
    // R9 quiet after error access
    chk("R9 idle pslverr", {31'h0, pslverr}, 32'h0);
    chk("R9 idle prdata", prdata, 32'h0);

    // R3 out-of-range select
    wr32(8'h14, 32'h7, "R3 select 7");
    rd(8'h08, 32'h0, 1'b1, "R3 bad select period");
    apb(1'b1, 8'h10, 32'h1111, 4'b1111, 32'h0, 1'b1, "R3 bad select write");
    chk("R3 dead kept", {16'h0, ch_dead_o[2*16 +: 16]}, 32'h0010);
    rd(8'h00, 32'h0000_ABCD, 1'b0, "R3 clock with bad select");
    rd(8'h14, 32'h7, 1'b0, "R3 select read 7");

    repeat (3) @(negedge clk);
    chk("queue drained", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule